// File: doc/BRIEF.md
# Directed-Rounding Mantissa Rounder

This block rounds one unpacked floating-point significand per cycle. The significand arrives with two extra bits at the bottom: bit 1 is the guard bit and bit 0 is the round bit. A separate sticky flag stands for every lower bit that was already shifted away. The block drops the two extra bits, decides from the rounding mode and the sign whether to add one unit in the last place, and performs that addition with full carry propagation. The result leaves through a one-stage output register, together with three flags:

- a rounded-up flag;
- an inexact flag;
- a verdict on whether an overflow in the current mode and sign should saturate to infinity or to the largest finite value.

The rounding mode is a 2-bit field: 0 rounds to nearest-even, 1 rounds toward zero, 2 rounds toward plus infinity and 3 rounds toward minus infinity. The result is one bit wider than the kept significand. When an all-ones significand is incremented, the top bit carries, which is the value 2.0 in normalised terms. Renormalising, adjusting the exponent and packing are left to the caller.

The output stage is a two-state machine:

- ST_EMPTY holds no result.
- ST_FULL presents a result and drives `valid_out`.
- Transition `capture`: ST_EMPTY goes to ST_FULL on `valid_in`.
- Transition `refill`: ST_FULL stays in ST_FULL on `valid_in`.
- Transition `drain`: ST_FULL goes to ST_EMPTY without `valid_in`.
- Transition `idle`: ST_EMPTY stays in ST_EMPTY without `valid_in`.

Top module: `mant_rounder`

## Requirements
- R1: After reset, `valid_out`, `mant_out` and all three flags are 0.
- R2: `valid_out` is 1 in the cycle after an edge where `valid_in` was 1, and 0 in the cycle after an edge where `valid_in` was 0.
- R3: When guard (bit 1), round (bit 0) and sticky are all 0, `mant_out` equals `mant_in` shifted right by two, and both `round_up_out` and `inexact_out` are 0.
- R4: When any of guard, round or sticky is 1, `inexact_out` is 1 in every mode.
- R5: In mode 0, the significand is incremented only when guard is 1 and at least one of these holds: round is 1, sticky is 1, or the LSB of the shifted significand (bit 2 of `mant_in`) is 1. A tie therefore rounds to even.
- R6: In mode 1, the significand is never incremented.
- R7: In mode 2, an inexact value is incremented only when `sign_in` is 0. In mode 3, an inexact value is incremented only when `sign_in` is 1.
- R8: The increment carries through every bit. An all-ones kept significand that is incremented yields `mant_out` with only its top bit (bit MANT_W) set.
- R9: `ovf_inf_out` is 1 in mode 0, 0 in mode 1, equal to NOT sign in mode 2 and equal to sign in mode 3. It does not depend on the significand.
- R10: `mant_out` always equals the shifted input plus `round_up_out`.
- R11: While `valid_in` is 0, `mant_out` and the flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Input operands are valid this cycle |
| sign_in | input | 1 | Sign of the value, 1 = negative |
| sticky_in | input | 1 | OR of all bits below the round bit |
| mode_in | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_in | input | MANT_W+2 | Significand; bit 1 is guard, bit 0 is round |
| valid_out | output | 1 | A registered result is present |
| mant_out | output | MANT_W+1 | Rounded significand; bit MANT_W is the carry-out |
| round_up_out | output | 1 | The significand was incremented |
| inexact_out | output | 1 | Guard, round or sticky was nonzero |
| ovf_inf_out | output | 1 | An overflow should saturate to infinity rather than to the largest finite value |

## Verification
The bench aims at the tie cases of nearest mode: an even LSB must stay put and an odd LSB must round up. A rounder that ignores the LSB, or that treats the round bit as the guard bit, gives the wrong parity there. It also pairs each directed mode with both signs, which exposes a swapped plus-infinity/minus-infinity decode or an inverted sign test. It drives all-ones significands into an increment, where a carry chain that drops its top carry would return zero instead of 2.0. Finally, it drops `valid_in` while changing the inputs: an output register that reloads without `valid_in` would lose the held result, and a wrong state machine would keep `valid_out` high.

// File: rtl/mant_rnd_pkg.sv
package mant_rnd_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_POS  = 2'd2,
        RM_NEG  = 2'd3
    } rnd_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import mant_rnd_pkg::*;
(
    input  rnd_mode_e mode,
    input  logic      sign,
    input  logic      guard,
    input  logic      rbit,
    input  logic      sticky,
    input  logic      lsb,
    output logic      incr,
    output logic      inexact,
    output logic      to_inf
);

    always_comb begin
        inexact = guard | rbit | sticky;
        incr    = 1'b0;
        to_inf  = 1'b1;
        unique case (mode)
            RM_NEAR: begin
                incr   = guard & (rbit | sticky | lsb);
                to_inf = 1'b1;
            end
            RM_ZERO: begin
                incr   = 1'b0;
                to_inf = 1'b0;
            end
            RM_POS: begin
                incr   = inexact & ~sign;
                to_inf = ~sign;
            end
            RM_NEG: begin
                incr   = inexact & sign;
                to_inf = sign;
            end
        endcase
    end

    // R5: nearest mode never increments without the guard bit
    always_comb begin
        if (mode == RM_NEAR && !guard) begin
            assert (!incr) else $error("p_near_guard_r5");
        end
    end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] base,
    input  logic             incr,
    output logic [WIDTH:0]   sum
);

    logic [WIDTH:0] carry;

    assign carry[0] = incr;

    // Half-adder chain: one stage per significand bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_chain
        assign sum[i]     = base[i] ^ carry[i];
        assign carry[i+1] = base[i] & carry[i];
    end

    assign sum[WIDTH] = carry[WIDTH];

endmodule

// File: rtl/mant_rounder.sv
module mant_rounder
    import mant_rnd_pkg::*;
#(
    parameter int MANT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic              sign_in,
    input  logic              sticky_in,
    input  logic [1:0]        mode_in,
    input  logic [MANT_W+1:0] mant_in,
    output logic              valid_out,
    output logic [MANT_W:0]   mant_out,
    output logic              round_up_out,
    output logic              inexact_out,
    output logic              ovf_inf_out
);

    localparam int IN_W = MANT_W + 2;

    out_state_e        state_q, state_d;
    logic [MANT_W-1:0] kept;
    logic [MANT_W:0]   rounded;
    logic              do_incr, is_inexact, go_inf;

    assign kept = mant_in[IN_W-1:2];

    rnd_decide u_decide (
        .mode    (rnd_mode_e'(mode_in)),
        .sign    (sign_in),
        .guard   (mant_in[1]),
        .rbit    (mant_in[0]),
        .sticky  (sticky_in),
        .lsb     (mant_in[2]),
        .incr    (do_incr),
        .inexact (is_inexact),
        .to_inf  (go_inf)
    );

    rnd_incr #(.WIDTH(MANT_W)) u_incr (
        .base (kept),
        .incr (do_incr),
        .sum  (rounded)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = valid_in ? ST_FULL : ST_EMPTY;  // capture / idle
            ST_FULL:  state_d = valid_in ? ST_FULL : ST_EMPTY;  // refill / drain
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output register: loads on valid_in, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mant_out     <= '0;
            round_up_out <= 1'b0;
            inexact_out  <= 1'b0;
            ovf_inf_out  <= 1'b0;
        end else if (valid_in) begin
            mant_out     <= rounded;
            round_up_out <= do_incr;
            inexact_out  <= is_inexact;
            ovf_inf_out  <= go_inf;
        end
    end

    assign valid_out = (state_q == ST_FULL);

    p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    p_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mant_in[1:0] == 2'b00 && !sticky_in) |=> (!round_up_out && !inexact_out));
    p_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && (mant_in[1:0] != 2'b00 || sticky_in)) |=> inexact_out);
    p_rz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode_in == 2'd1) |=> (!round_up_out && !ovf_inf_out));
    p_near_inf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode_in == 2'd0) |=> ovf_inf_out);
    p_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (mant_out == ({1'b0, $past(mant_in[IN_W-1:2])}
                                   + {{MANT_W{1'b0}}, round_up_out})));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(mant_out) && $stable(round_up_out) && $stable(inexact_out)));

endmodule

// File: tb/test_mant_rounder.sv
`timescale 1ns/1ps
module test_mant_rounder;

    localparam int MW = 24;
    localparam int NV = 16;
    // {mode[2], sign, sticky, mant_in[26], exp_mant[25], exp_up, exp_nx, exp_inf}
    localparam int VW = 2 + 1 + 1 + (MW + 2) + (MW + 1) + 3;

    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 26'h0000008, 25'h0000002, 1'b0, 1'b0, 1'b1}, // R3 exact
        {2'd0, 1'b0, 1'b0, 26'h000000A, 25'h0000002, 1'b0, 1'b1, 1'b1}, // R5 tie even
        {2'd0, 1'b0, 1'b0, 26'h000000E, 25'h0000004, 1'b1, 1'b1, 1'b1}, // R5 tie odd
        {2'd0, 1'b0, 1'b1, 26'h000000A, 25'h0000003, 1'b1, 1'b1, 1'b1}, // R5 sticky
        {2'd0, 1'b0, 1'b0, 26'h0000009, 25'h0000002, 1'b0, 1'b1, 1'b1}, // R5 round only
        {2'd0, 1'b1, 1'b0, 26'h000000B, 25'h0000003, 1'b1, 1'b1, 1'b1}, // R5 neg
        {2'd1, 1'b0, 1'b0, 26'h000000F, 25'h0000003, 1'b0, 1'b1, 1'b0}, // R6
        {2'd1, 1'b1, 1'b1, 26'h0000008, 25'h0000002, 1'b0, 1'b1, 1'b0}, // R6 R4 sticky
        {2'd2, 1'b0, 1'b0, 26'h0000009, 25'h0000003, 1'b1, 1'b1, 1'b1}, // R7 +inf pos
        {2'd2, 1'b1, 1'b0, 26'h0000009, 25'h0000002, 1'b0, 1'b1, 1'b0}, // R7 +inf neg
        {2'd3, 1'b1, 1'b1, 26'h0000004, 25'h0000002, 1'b1, 1'b1, 1'b1}, // R7 -inf neg
        {2'd3, 1'b0, 1'b1, 26'h0000004, 25'h0000001, 1'b0, 1'b1, 1'b0}, // R7 -inf pos
        {2'd2, 1'b0, 1'b0, 26'h0000004, 25'h0000001, 1'b0, 1'b0, 1'b1}, // R3 exact directed
        {2'd0, 1'b0, 1'b0, 26'h3FFFFFE, 25'h1000000, 1'b1, 1'b1, 1'b1}, // R8 carry
        {2'd3, 1'b1, 1'b0, 26'h3FFFFFF, 25'h1000000, 1'b1, 1'b1, 1'b1}, // R8 carry -inf
        {2'd1, 1'b0, 1'b0, 26'h3FFFFFF, 25'h0FFFFFF, 1'b0, 1'b1, 1'b0}  // R8 no carry rz
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic          sign_in = 1'b0;
    logic          sticky_in = 1'b0;
    logic [1:0]    mode_in = 2'd0;
    logic [MW+1:0] mant_in = '0;
    logic          valid_out;
    logic [MW:0]   mant_out;
    logic          round_up_out, inexact_out, ovf_inf_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mant_rounder #(.MANT_W(MW)) i_mant_rounder (
        .clk, .rst_n, .valid_in, .sign_in, .sticky_in, .mode_in, .mant_in,
        .valid_out, .mant_out, .round_up_out, .inexact_out, .ovf_inf_out
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [VW-1:0] v);
        check({req, " mant"},  64'(mant_out),     64'(v[MW+3:3]));
        check({req, " up"},    64'(round_up_out), 64'(v[2]));
        check({req, " nx"},    64'(inexact_out),  64'(v[1]));
        check({req, " inf"},   64'(ovf_inf_out),  64'(v[0]));
        check({req, " valid"}, 64'(valid_out),    64'd1);
    endtask

    initial begin
        logic [VW-1:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", 64'(valid_out), 64'd0);
        check("R1 mant", 64'(mant_out), 64'd0);
        check("R1 flags", 64'({round_up_out, inexact_out, ovf_inf_out}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", 64'(valid_out), 64'd0);

        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            valid_in  = 1'b1;
            mode_in   = v[VW-1:VW-2];
            sign_in   = v[VW-3];
            sticky_in = v[VW-4];
            mant_in   = v[VW-5:MW+4];
            @(negedge clk);
            check_vec($sformatf("R10 vec%0d", k), v);
        end

        // R11 / R2: drop valid with changed inputs; held outputs stay
        valid_in = 1'b0;
        mode_in  = 2'd0; sign_in = 1'b0; sticky_in = 1'b1; mant_in = 26'h0000002;
        @(negedge clk);
        check("R2 drain", 64'(valid_out), 64'd0);
        check("R11 mant hold", 64'(mant_out), 64'h0FFFFFF);
        check("R11 flag hold", 64'({round_up_out, inexact_out, ovf_inf_out}), 64'b010);
        @(negedge clk);
        check("R11 mant hold 2", 64'(mant_out), 64'h0FFFFFF);

        // R9: mode 3 positive exact, overflow verdict independent of significand
        valid_in = 1'b1; mode_in = 2'd3; sign_in = 1'b0; sticky_in = 1'b0; mant_in = 26'h3FFFFFC;
        @(negedge clk);
        check("R9 mant", 64'(mant_out), 64'h0FFFFFF);
        check("R9 inf", 64'(ovf_inf_out), 64'd0);
        check("R3 up", 64'(round_up_out), 64'd0);
        // R4 round bit alone in toward-zero mode
        mode_in = 2'd1; mant_in = 26'h0000001;
        @(negedge clk);
        check("R4 nx", 64'(inexact_out), 64'd1);
        check("R6 up", 64'(round_up_out), 64'd0);
        valid_in = 1'b0;
        @(negedge clk);
        check("R2 drain 2", 64'(valid_out), 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule